// File: doc/BRIEF.md
# Current-Fault Limited Retry Controller

This block is the digital sequencer behind a hot-swap switch. It decides when the pass-transistor gate driver may be enabled. An external comparator reports when the analog loop is holding the load current at its limit. The block measures how long that condition lasts. A short episode is tolerated, and the gate stays enabled while the loop regulates. If the limit is held for a full on-time, a fault is registered, the gate is switched off for a cooldown, and the block then retries.

The cooldown is derived from the on-time so that the retry duty is 3 %. Seven consecutive faults latch the block off. A retry that ends with the current limit inactive counts as a clean start and clears the fault count. A qualified supply-window flag gates everything. When the window goes bad, the gate drops at once, and a power-on delay must run again before the gate returns. All timing is counted in prescaled ticks.

Top module: `retry_gate_ctrl`

## Requirements
- R1: After the supply window becomes valid, gate_en stays low for POR_TICKS ticks and is then asserted.
- R2: When win_ok is low at a clock edge, gate_en is low after that edge, and a fresh power-on delay runs before gate_en returns.
- R3: A current-limit episode shorter than the on-time registers no fault, and gate_en stays high throughout.
- R4: A current limit held for the whole on-time registers a fault: fault_pulse is high for exactly one cycle, fault_count rises by one, and gate_en goes low.
- R5: After a fault, gate_en stays low for an off-time of on-time*100/3 ticks (integer division). gate_en is then raised again for a probe on-time.
- R6: The seventh consecutive fault sets latched_off, holds gate_en low, and leaves fault_count at 7.
- R7: A probe that ends with ilim_active low clears fault_count to 0 and leaves gate_en high.
- R8: latched_off is cleared only by reset or by win_ok going low. Clearing the latch also clears fault_count. ilim_active going low does not release the latch.
- R9: A window drop during an on-time or an off-time aborts the cycle but keeps fault_count.
- R10: on_sel = 0 selects the short on-time ON_TICKS_SHORT, and on_sel = 1 selects the long on-time ON_TICKS_LONG. The off-time follows the selected on-time.
- R11: Reset drives gate_en, latched_off, fault_pulse and fault_count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_ok | input | 1 | Debounced supply-window-valid flag |
| ilim_active | input | 1 | Current-limit comparator active |
| on_sel | input | 1 | On-time select: 0 short, 1 long |
| gate_en | output | 1 | Gate driver enable |
| latched_off | output | 1 | Latched off after the consecutive fault limit |
| fault_count | output | CNT_W | Consecutive fault count |
| fault_pulse | output | 1 | One-cycle pulse per registered fault |

## Verification
The bench builds the block with PRESCALE = 2, POR_TICKS = 5, ON_TICKS_SHORT = 4 and ON_TICKS_LONG = 8, with the fault limit left at seven. With these values one full retry cycle lasts a few hundred clocks. The whole march to latch-off, the clean-probe counter clear, the window-drop aborts and both on-time selections therefore fit in one short run. A prescale of two also exercises the divider, so tick-phase errors show up as shifted edges.

// File: rtl/retry_pkg.sv
package retry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_POR   = 3'd1,
    ST_RUN   = 3'd2,
    ST_LIMIT = 3'd3,
    ST_COOL  = 3'd4,
    ST_PROBE = 3'd5,
    ST_LATCH = 3'd6
  } rg_state_e;
endpackage

// File: rtl/rg_phase_timer.sv
module rg_phase_timer #(
  parameter int PRESCALE = 1000,
  parameter int TICK_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [TICK_W-1:0] target,
  output logic              done
);
  logic tick;
  logic [TICK_W-1:0] ticks;

  generate
    if (PRESCALE > 1) begin : g_div
      localparam int PS_W = $clog2(PRESCALE);
      localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
      logic [PS_W-1:0] div;
      always_ff @(posedge clk) begin
        if (rst || restart) div <= '0;
        else if (div == PS_LAST) div <= '0;
        else div <= div + 1'b1;
      end
      assign tick = (div == PS_LAST);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  assign done = (ticks == target);

  always_ff @(posedge clk) begin
    if (rst || restart) ticks <= '0;
    else if (tick && !done) ticks <= ticks + 1'b1;
  end

  assert_timer_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    (!restart && done) |=> (ticks == $past(ticks)));
endmodule

// File: rtl/rg_fault_tally.sv
module rg_fault_tally #(
  parameter int LIMIT = 7,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             at_last
);
  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (bump && count != CNT_W'(LIMIT)) count <= count + 1'b1;
  end

  assign at_last = (count == CNT_W'(LIMIT - 1));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(LIMIT));
  assert_bump_step_R4: assert property (@(posedge clk) disable iff (rst)
    (bump && !clear && count != CNT_W'(LIMIT)) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/retry_gate_ctrl.sv
module retry_gate_ctrl
  import retry_pkg::*;
#(
  parameter int PRESCALE       = 1000,
  parameter int POR_TICKS      = 10,
  parameter int ON_TICKS_SHORT = 14,
  parameter int ON_TICKS_LONG  = 56,
  parameter int DUTY_NUM       = 3,
  parameter int DUTY_DEN       = 100,
  parameter int FAULT_LIMIT    = 7,
  localparam int CNT_W         = $clog2(FAULT_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_ok,
  input  logic             ilim_active,
  input  logic             on_sel,
  output logic             gate_en,
  output logic             latched_off,
  output logic [CNT_W-1:0] fault_count,
  output logic             fault_pulse
);
  localparam int OFF_SHORT = ON_TICKS_SHORT * DUTY_DEN / DUTY_NUM;
  localparam int OFF_LONG  = ON_TICKS_LONG * DUTY_DEN / DUTY_NUM;
  localparam int MAX_A     = (OFF_SHORT > OFF_LONG) ? OFF_SHORT : OFF_LONG;
  localparam int MAX_T     = (MAX_A > POR_TICKS) ? MAX_A : POR_TICKS;
  localparam int TICK_W    = $clog2(MAX_T + 1);

  rg_state_e st, st_nxt;
  logic [TICK_W-1:0] target;
  logic done, fault_evt, clean_probe, latch_clear, at_last;

  always_comb begin
    unique case (st)
      ST_POR:              target = TICK_W'(POR_TICKS);
      ST_LIMIT, ST_PROBE:  target = on_sel ? TICK_W'(ON_TICKS_LONG) : TICK_W'(ON_TICKS_SHORT);
      ST_COOL:             target = on_sel ? TICK_W'(OFF_LONG) : TICK_W'(OFF_SHORT);
      default:             target = '0;
    endcase
  end

  assign fault_evt   = win_ok && ilim_active && done && (st == ST_LIMIT || st == ST_PROBE);
  assign clean_probe = win_ok && !ilim_active && done && (st == ST_PROBE);
  assign latch_clear = !win_ok && (st == ST_LATCH);

  always_comb begin
    st_nxt = st;
    if (!win_ok) st_nxt = ST_IDLE;
    else begin
      unique case (st)
        ST_IDLE:  st_nxt = ST_POR;
        ST_POR:   if (done) st_nxt = ST_RUN;
        ST_RUN:   if (ilim_active) st_nxt = ST_LIMIT;
        ST_LIMIT: if (!ilim_active) st_nxt = ST_RUN;
                  else if (done) st_nxt = at_last ? ST_LATCH : ST_COOL;
        ST_COOL:  if (done) st_nxt = ST_PROBE;
        ST_PROBE: if (done) st_nxt = ilim_active ? (at_last ? ST_LATCH : ST_COOL) : ST_RUN;
        ST_LATCH: st_nxt = ST_LATCH;
        default:  st_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      gate_en     <= 1'b0;
      latched_off <= 1'b0;
      fault_pulse <= 1'b0;
    end else begin
      st          <= st_nxt;
      gate_en     <= (st_nxt == ST_RUN) || (st_nxt == ST_LIMIT) || (st_nxt == ST_PROBE);
      latched_off <= (st_nxt == ST_LATCH);
      fault_pulse <= fault_evt;
    end
  end

  rg_phase_timer #(.PRESCALE(PRESCALE), .TICK_W(TICK_W)) u_timer (
    .clk(clk), .rst(rst), .restart(st_nxt != st), .target(target), .done(done)
  );

  rg_fault_tally #(.LIMIT(FAULT_LIMIT), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .bump(fault_evt), .clear(clean_probe || latch_clear),
    .count(fault_count), .at_last(at_last)
  );

  assert_window_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !win_ok |=> !gate_en);
  assert_latch_gate_low_R6: assert property (@(posedge clk) disable iff (rst)
    latched_off |-> !gate_en);
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    fault_pulse |=> !fault_pulse);
  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (latched_off && win_ok) |=> latched_off);
  assert_fault_gate_off_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_pulse) |-> !gate_en);
endmodule

// File: tb/sim_retry_gate_ctrl.sv
module sim_retry_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  typedef struct packed {
    logic        w;
    logic        l;
    logic        s;
    logic [15:0] n;
    logic        g;
    logic        lt;
    logic [2:0]  c;
    logic [7:0]  r;
  } vec_t;

  // fields: win, ilim, on_sel, cycles, exp gate, exp latched, exp count, requirement
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 16'd8,    1'b0, 1'b0, 3'd0, 8'd1},  // R1 still in delay
    '{1'b1, 1'b0, 1'b0, 16'd6,    1'b1, 1'b0, 3'd0, 8'd1},  // R1 gate up
    '{1'b1, 1'b1, 1'b0, 16'd4,    1'b1, 1'b0, 3'd0, 8'd3},  // R3 glitch
    '{1'b1, 1'b0, 1'b0, 16'd20,   1'b1, 1'b0, 3'd0, 8'd3},  // R3 no fault
    '{1'b1, 1'b1, 1'b0, 16'd6,    1'b1, 1'b0, 3'd0, 8'd4},  // R4 regulating
    '{1'b1, 1'b1, 1'b0, 16'd6,    1'b0, 1'b0, 3'd1, 8'd4},  // R4 fault
    '{1'b1, 1'b1, 1'b0, 16'd250,  1'b0, 1'b0, 3'd1, 8'd5},  // R5 still cooling
    '{1'b1, 1'b1, 1'b0, 16'd20,   1'b1, 1'b0, 3'd1, 8'd5},  // R5 probe on
    '{1'b1, 1'b1, 1'b0, 16'd6,    1'b0, 1'b0, 3'd2, 8'd5},  // R5 second fault
    '{1'b1, 1'b1, 1'b0, 16'd1400, 1'b0, 1'b1, 3'd7, 8'd6},  // R6 latched
    '{1'b1, 1'b0, 1'b0, 16'd300,  1'b0, 1'b1, 3'd7, 8'd8},  // R8 limit gone, latch stays
    '{1'b0, 1'b0, 1'b0, 16'd4,    1'b0, 1'b0, 3'd0, 8'd8},  // R8 window clears latch
    '{1'b1, 1'b0, 1'b0, 16'd14,   1'b1, 1'b0, 3'd0, 8'd8},  // R8 restart
    '{1'b1, 1'b1, 1'b0, 16'd12,   1'b0, 1'b0, 3'd1, 8'd7},  // R7 fault
    '{1'b1, 1'b0, 1'b0, 16'd280,  1'b1, 1'b0, 3'd0, 8'd7},  // R7 clean probe
    '{1'b1, 1'b1, 1'b0, 16'd12,   1'b0, 1'b0, 3'd1, 8'd9},  // R9 fault
    '{1'b0, 1'b1, 1'b0, 16'd50,   1'b0, 1'b0, 3'd1, 8'd9},  // R9 abort keeps count
    '{1'b1, 1'b0, 1'b0, 16'd8,    1'b0, 1'b0, 3'd1, 8'd9},  // R9 delay again
    '{1'b1, 1'b0, 1'b0, 16'd6,    1'b1, 1'b0, 3'd1, 8'd9},  // R9 restored
    '{1'b0, 1'b0, 1'b0, 16'd1,    1'b0, 1'b0, 3'd1, 8'd2},  // R2 immediate drop
    '{1'b1, 1'b0, 1'b0, 16'd8,    1'b0, 1'b0, 3'd1, 8'd2},  // R2 delay reruns
    '{1'b1, 1'b0, 1'b0, 16'd6,    1'b1, 1'b0, 3'd1, 8'd2},  // R2 back
    '{1'b1, 1'b1, 1'b1, 16'd14,   1'b1, 1'b0, 3'd1, 8'd10}, // R10 long on-time holds
    '{1'b1, 1'b1, 1'b1, 16'd6,    1'b0, 1'b0, 3'd2, 8'd10}  // R10 long fault
  };

  logic clk = 1'b0;
  logic rst, win_ok, ilim_active, on_sel;
  logic gate_en, latched_off, fault_pulse;
  logic [2:0] fault_count;
  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  retry_gate_ctrl #(
    .PRESCALE(2), .POR_TICKS(5), .ON_TICKS_SHORT(4), .ON_TICKS_LONG(8)
  ) u0 (
    .clk(clk), .rst(rst), .win_ok(win_ok), .ilim_active(ilim_active), .on_sel(on_sel),
    .gate_en(gate_en), .latched_off(latched_off), .fault_count(fault_count),
    .fault_pulse(fault_pulse)
  );

  always @(negedge clk) if (!rst && fault_pulse) pulses++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; win_ok = 1'b0; ilim_active = 1'b0; on_sel = 1'b0;
    wait_cycles(3);
    check("R11 gate", gate_en, 0);
    check("R11 latch", latched_off, 0);
    check("R11 count", fault_count, 0);
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      win_ok = VEC[k].w; ilim_active = VEC[k].l; on_sel = VEC[k].s;
      wait_cycles(VEC[k].n);
      check($sformatf("R%0d vec%0d gate", VEC[k].r, k), gate_en, VEC[k].g);
      check($sformatf("R%0d vec%0d latch", VEC[k].r, k), latched_off, VEC[k].lt);
      check($sformatf("R%0d vec%0d count", VEC[k].r, k), fault_count, VEC[k].c);
    end
    check("R4 fault pulses", pulses, 10);
    // R11: reset in the middle of a cooldown
    rst = 1'b1;
    wait_cycles(2);
    check("R11 mid reset gate", gate_en, 0);
    check("R11 mid reset count", fault_count, 0);
    check("R11 mid reset pulse", fault_pulse, 0);
    rst = 1'b0; ilim_active = 1'b0; on_sel = 1'b0;
    wait_cycles(8);
    check("R1 after reset", gate_en, 0);
    wait_cycles(6);
    check("R1 after reset up", gate_en, 1);
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule